// File: doc/BRIEF.md
# Attribute Palette Color Path

This block turns a stream of pixel values into 24-bit RGB colour. A pixel goes through two lookups. The first stage maps the pixel to an 8-bit colour-table index. In the narrow pixel mode, the low nibble picks one of 16 six-bit attribute entries, and a colour-select register supplies the top index bits. In the direct pixel mode, the pixel value is the index itself. The second stage reads a 256-entry colour table that holds three 6-bit channels per entry. Each channel is widened to 8 bits.

Software loads the attribute entries, the colour-select byte and the two mode bits through a small configuration write port. The colour table has its own write port. Pixels enter with a valid strobe, and the RGB word leaves with a valid strobe two clock edges later.

Top module: `attr_dac_color_path`

## Requirements
- R1: When mode bit 0 (direct pixel) is set, the colour-table index equals the full 8-bit pixel value.
- R2: When mode bit 0 is clear, pixel bits 3:0 select one of the 16 attribute entries. Index bits 3:0 are that entry's bits 3:0, and pixel bits 7:4 have no effect.
- R3: When mode bit 0 is clear and mode bit 1 is set, index bits 5:4 come from colour-select bits 5:4. When mode bit 1 is clear, they come from entry bits 5:4.
- R4: When mode bit 0 is clear, index bits 7:6 always come from colour-select bits 7:6.
- R5: A colour-table word holds red in bits 5:0, green in bits 13:8 and blue in bits 21:16. The output carries red in rgb[23:16], green in rgb[15:8] and blue in rgb[7:0]. Each 6-bit channel is shifted left two places, so its two low bits are zero.
- R6: `out_valid` follows `pix_valid` with a fixed latency of two clock edges. Every accepted pixel produces exactly one output.
- R7: A write to an attribute entry or a colour-table entry, made in the same cycle as a lookup that reads that entry, leaves the lookup with the old value.
- R8: Reset clears `out_valid`, `rgb`, all attribute entries, the colour-select byte and both mode bits.
- R9: The configuration map is as follows: addresses 0 to 15 are attribute entries (data bits 5:0), address 16 is colour-select, and address 17 holds the mode bits in data bits 1:0. Writes to other addresses, and colour-table word bits outside the three channel fields, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_idx | input | 8 | Pixel value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration address |
| cfg_data | input | 8 | Configuration write data |
| dac_we | input | 1 | Colour-table write enable |
| dac_addr | input | 8 | Colour-table entry address |
| dac_data | input | 24 | Colour-table word |
| out_valid | output | 1 | RGB strobe |
| rgb | output | 24 | Red, green, blue bytes |

## Verification
Both kinds of table write can land in the same cycle as a lookup of the entry being written. An attribute write can meet a pixel in stage one, and a colour-table write can meet the index held in stage two.

Directed cases place each write on exactly that cycle. The random phase makes many more collisions by issuing writes on random cycles while pixels stream in. A reference model in the bench applies each write only after the lookup of the same cycle has been computed, so a design that forwards the new data disagrees with the model and is reported.

// File: rtl/attr_dac_color_path.sv
module attr_dac_color_path #(
  parameter int PIX_W = 8,
  parameter int PAL_N = 16,
  parameter int PAL_W = 6,
  parameter int CH_W  = 6,
  parameter int OUT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pix_valid,
  input  logic [PIX_W-1:0]     pix_idx,
  input  logic                 cfg_we,
  input  logic [4:0]           cfg_addr,
  input  logic [7:0]           cfg_data,
  input  logic                 dac_we,
  input  logic [PIX_W-1:0]     dac_addr,
  input  logic [3*OUT_W-1:0]   dac_data,
  output logic                 out_valid,
  output logic [3*OUT_W-1:0]   rgb
);
  localparam int DAC_N  = 1 << PIX_W;
  localparam int PAL_AW = $clog2(PAL_N);
  localparam int A_CSEL = PAL_N;
  localparam int A_MODE = PAL_N + 1;
  localparam int PAD    = OUT_W - CH_W;

  logic [PAL_W-1:0]  pal_q [PAL_N];
  logic [7:0]        colsel_q;
  logic              wide_q, sel54_q;
  logic [3*CH_W-1:0] dac_mem [DAC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) pal_q[i] <= '0;
      colsel_q <= '0;
      wide_q   <= 1'b0;
      sel54_q  <= 1'b0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) < PAL_N)       pal_q[cfg_addr[PAL_AW-1:0]] <= cfg_data[PAL_W-1:0];
      else if (int'(cfg_addr) == A_CSEL) colsel_q <= cfg_data;
      else if (int'(cfg_addr) == A_MODE) {sel54_q, wide_q} <= cfg_data[1:0];
    end
  end

  always_ff @(posedge clk)
    if (dac_we)
      dac_mem[dac_addr] <= {dac_data[2*OUT_W+CH_W-1 -: CH_W],
                            dac_data[OUT_W+CH_W-1 -: CH_W],
                            dac_data[CH_W-1:0]};

  logic [PAL_W-1:0] ent;
  logic [PIX_W-1:0] idx_d, idx_q;
  logic             v1_q;

  assign ent   = pal_q[pix_idx[PAL_AW-1:0]];
  assign idx_d = wide_q ? pix_idx
                        : {colsel_q[7:6], sel54_q ? colsel_q[5:4] : ent[5:4], ent[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      v1_q <= pix_valid;
      if (pix_valid) idx_q <= idx_d;
    end
  end

  logic [3*CH_W-1:0] word;
  assign word = dac_mem[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rgb       <= '0;
    end else begin
      out_valid <= v1_q;
      if (v1_q)
        rgb <= {word[CH_W-1:0], PAD'(0),
                word[2*CH_W-1 -: CH_W], PAD'(0),
                word[3*CH_W-1 -: CH_W], PAD'(0)};
    end
  end
endmodule

// File: rtl/attr_dac_color_path_chk.sv
module attr_dac_color_path_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_valid,
  input logic [7:0]  pix_idx,
  input logic        out_valid,
  input logic [23:0] rgb,
  input logic [7:0]  idx_q,
  input logic [7:0]  colsel_q,
  input logic        wide_q,
  input logic        sel54_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;

  assert_direct_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && wide_q) |=> idx_q == $past(pix_idx));

  assert_override_54_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !wide_q && sel54_q) |=> idx_q[5:4] == $past(colsel_q[5:4]));

  assert_top_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !wide_q) |=> idx_q[7:6] == $past(colsel_q[7:6]));

  assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rgb[1:0] == 2'b0 && rgb[9:8] == 2'b0 && rgb[17:16] == 2'b0));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> out_valid == $past(pix_valid, 2));

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && rgb == 24'h0));
endmodule

bind attr_dac_color_path attr_dac_color_path_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_idx(pix_idx),
  .out_valid(out_valid), .rgb(rgb), .idx_q(idx_q), .colsel_q(colsel_q),
  .wide_q(wide_q), .sel54_q(sel54_q)
);

// File: tb/attr_dac_color_path_bench.sv
module attr_dac_color_path_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_idx = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        dac_we = 1'b0;
  logic [7:0]  dac_addr = '0;
  logic [23:0] dac_data = '0;
  logic        out_valid;
  logic [23:0] rgb;

  always #4 clk = ~clk;

  attr_dac_color_path u_attr_dac_color_path (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_idx(pix_idx),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .dac_we(dac_we), .dac_addr(dac_addr), .dac_data(dac_data),
    .out_valid(out_valid), .rgb(rgb)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [5:0]  m_pal [16];
  logic [7:0]  m_csel;
  logic        m_wide, m_sel54;
  logic [23:0] m_dac [256];

  logic        ev1 = 0, ev2 = 0;
  logic [7:0]  ei1 = 0;
  logic [23:0] er2 = 0;
  string       t1 = "", t2 = "";

  function automatic logic [7:0] idx_of(logic [7:0] p);
    logic [5:0] e;
    e = m_pal[p[3:0]];
    if (m_wide) return p;
    return {m_csel[7:6], m_sel54 ? m_csel[5:4] : e[5:4], e[3:0]};
  endfunction

  function automatic logic [23:0] rgb_of(logic [23:0] w);
    return {w[5:0], 2'b00, w[13:8], 2'b00, w[21:16], 2'b00};
  endfunction

  function automatic string auto_tag();
    if (m_wide) return "R1";
    if (m_sel54) return "R3";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] p,
                      input logic cw, input logic [4:0] ca, input logic [7:0] cd,
                      input logic dw, input logic [7:0] da, input logic [23:0] dd,
                      input string tag);
    @(negedge clk);
    chk("R6", {23'b0, out_valid}, {23'b0, ev2});
    if (ev2) chk(t2, rgb, er2);
    pix_valid = v; pix_idx = p;
    cfg_we = cw; cfg_addr = ca; cfg_data = cd;
    dac_we = dw; dac_addr = da; dac_data = dd;
    er2 = rgb_of(m_dac[ei1]);
    ev2 = ev1; t2 = t1;
    ei1 = v ? idx_of(p) : ei1;
    ev1 = v;
    t1 = (tag == "") ? auto_tag() : tag;
    if (cw) begin
      if (ca < 5'd16) m_pal[ca[3:0]] = cd[5:0];
      else if (ca == 5'd16) m_csel = cd;
      else if (ca == 5'd17) {m_sel54, m_wide} = cd[1:0];
    end
    if (dw) m_dac[da] = dd;
  endtask

  task automatic pix(input logic [7:0] p, input string tag);
    step(1'b1, p, 1'b0, 5'd0, 8'd0, 1'b0, 8'd0, 24'd0, tag);
  endtask

  task automatic cfg(input logic [4:0] a, input logic [7:0] d);
    step(1'b0, 8'd0, 1'b1, a, d, 1'b0, 8'd0, 24'd0, "");
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 16; i++) m_pal[i] = '0;
    m_csel = '0; m_wide = 0; m_sel54 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", {23'b0, out_valid}, 24'd0);
    chk("R8", rgb, 24'd0);
    rst_n = 1'b1;
    // fill colour table, index 0 first for the R8 zero-palette check
    for (int i = 0; i < 256; i++)
      step(1'b0, 8'd0, 1'b0, 5'd0, 8'd0, 1'b1, 8'(i), 24'($urandom), "");
    pix(8'h9B, "R8");              // cleared palette/colsel -> index 0
    for (int i = 0; i < 16; i++) cfg(5'(i), 8'($urandom));
    cfg(5'd16, 8'hC0);
    pix(8'h23, "R4");
    pix(8'hF3, "R2");              // upper nibble ignored
    cfg(5'd17, 8'h02);
    cfg(5'd16, 8'h9E);
    pix(8'h0A, "R3");
    cfg(5'd17, 8'h01);
    pix(8'h5C, "R1");
    pix(8'hFF, "R1");
    // same-cycle attribute write
    cfg(5'd17, 8'h00);
    step(1'b1, 8'h07, 1'b1, 5'd7, 8'h3F, 1'b0, 8'd0, 24'd0, "R7");
    pix(8'h07, "R7");
    // same-cycle colour-table write against stage-two read
    cfg(5'd17, 8'h01);
    pix(8'h44, "R7");
    step(1'b0, 8'd0, 1'b0, 5'd0, 8'd0, 1'b1, 8'h44, 24'h123456, "");
    pix(8'h44, "R5");
    step(1'b0, 8'd0, 1'b0, 5'd0, 8'd0, 1'b1, 8'h45, 24'hFFFFFF, "");
    pix(8'h45, "R9");
    cfg(5'd18, 8'h00);             // unmapped address ignored
    cfg(5'd31, 8'hFF);
    pix(8'h46, "R9");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic cw, dw;
      cw = ($urandom % 4) == 0;
      dw = ($urandom % 4) == 0;
      step(($urandom % 8) != 0, 8'($urandom),
           cw, 5'($urandom % 20), 8'($urandom),
           dw, 8'($urandom), 24'($urandom), "");
    end
    repeat (3) pix(8'h00, "R6");
    step(1'b0, 8'd0, 1'b0, 5'd0, 8'd0, 1'b0, 8'd0, 24'd0, "R6");
    step(1'b0, 8'd0, 1'b0, 5'd0, 8'd0, 1'b0, 8'd0, 24'd0, "R6");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule